// File: doc/BRIEF.md
# Rectangle Fill Colour-Expansion Engine

This block fills axis-aligned rectangles in a linear framebuffer. Software programs a destination origin, a 32-bit stipple pattern, a foreground colour, a background colour and a small control word. It then writes the rectangle size to a trigger alias of the size register. The engine walks the rectangle row by row. Each pixel slot takes one pattern bit, where lane k of every 32-pixel group uses bit 31-k, and that bit picks foreground, background or no write. Every written pixel goes out on a write port as a pixel address with a 32-bit data word. The line pitch is fixed at 2048 pixels.

All register writes pass through a 32-entry command queue. The queue only drains while no fill is running, so software can stream the set-up for the next fill while the current one is still in flight. Two read-only locations report whether the engine is busy and how many queue slots are free. When a fill ends, the destination Y moves down by the rectangle height, so fills stacked one under another need only a new size each time.

Top module: `rect_fill_engine`

## Requirements
- R1: Register byte offsets are: destination 0x000, size 0x004, pattern 0x008, foreground 0x00C, background 0x010, control 0x014. Destination and size words carry X or width in bits 31:16 and Y or height in bits 15:0. In the control word, bit 0 makes the background transparent and bit 1 enables right-edge clipping.
- R2: A write to offset 0x204 (the size offset OR'd with the fill opcode 0x200) latches the size and starts a fill. A write to 0x004 only latches the size and produces no pixel writes.
- R3: A fill visits pixel slots in row-major order, left to right, one slot per clock. The slot in column c uses pattern bit 31-(c mod 32). The pattern reloads the same way for every 32-pixel group and for every row.
- R4: When the pattern bit is set, the slot writes the foreground colour. When it is clear, the slot writes the background colour, or writes nothing when control bit 0 is set.
- R5: With control bit 1 set, only columns below the width are visited. With it clear, each row is padded up to the next multiple of 32 columns, and the padding pixels are also written.
- R6: When a fill with nonzero size ends, the destination Y increases by the height (modulo 2^16), and X is unchanged.
- R7: The write address of slot (row r, column c) is (Y+r)*2048 + (X+c), on 28 bits.
- R8: The byte at read offset 0x100 is nonzero while a fill runs or commands are still queued, and zero otherwise.
- R9: Up to 32 writes are queued and applied in arrival order, one per clock, while no fill runs. Read offset 0x104 returns the number of free slots. A write that arrives while the queue is full is discarded.
- R10: A trigger with zero width or zero height produces no pixel writes and leaves the destination unchanged.
- R11: After reset the engine is idle, 32 slots are free, no pixel is written, and all programmed registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| rd_addr | input | 12 | Status read offset |
| rd_data | output | 32 | Status read data (combinational) |
| mem_we | output | 1 | Pixel write request |
| mem_addr | output | 28 | Pixel address |
| mem_wdata | output | 32 | Pixel colour |

## Verification
The queue can accept a new command in the same cycle that it hands a trigger to the idle walker. Also, the cycle that ends a fill moves Y, and the command popped right after that fill must see the moved value. The bench provokes both. It writes a trigger and then streams 32 pattern writes on the following clocks, and it queues several fills back to back with no wait between them. It judges the result by two things: the free-slot count, which must read exactly zero at the end of the stream, and the order and addresses of the pixel writes, which are compared against a software model that applies the commands in order.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    localparam int REG_AW     = 12;
    localparam int PITCH_LOG2 = 11;
    localparam int MEM_AW     = 16 + PITCH_LOG2 + 1;
    localparam int GROUP      = 32;

    localparam logic [REG_AW-1:0] OFF_DST  = 12'h000;
    localparam logic [REG_AW-1:0] OFF_SIZE = 12'h004;
    localparam logic [REG_AW-1:0] OFF_PAT  = 12'h008;
    localparam logic [REG_AW-1:0] OFF_FG   = 12'h00C;
    localparam logic [REG_AW-1:0] OFF_BG   = 12'h010;
    localparam logic [REG_AW-1:0] OFF_CTRL = 12'h014;
    localparam logic [REG_AW-1:0] OP_FILL  = 12'h200;
    localparam logic [REG_AW-1:0] OFF_STAT = 12'h100;
    localparam logic [REG_AW-1:0] OFF_FREE = 12'h104;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [31:0]       data;
    } cmd_t;

    typedef struct packed {
        logic [15:0] x;
        logic [15:0] y;
    } xy_t;

    typedef struct packed {
        logic clip;
        logic transp;
    } ctrl_t;

    // number of columns visited per row
    function automatic logic [16:0] span_len(input logic [15:0] w, input logic clip);
        logic [16:0] wx;
        wx = {1'b0, w};
        return clip ? wx : ((wx + 17'(GROUP - 1)) & ~17'(GROUP - 1));
    endfunction

    function automatic logic [MEM_AW-1:0] pixel_addr(input xy_t org, input logic [15:0] row,
                                                     input logic [15:0] col);
        logic [15:0] py;
        logic [15:0] px;
        py = org.y + row;
        px = org.x + col;
        return (MEM_AW'(py) << PITCH_LOG2) + MEM_AW'(px);
    endfunction
endpackage

// File: rtl/rfe_cmd_fifo.sv
module rfe_cmd_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 44
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] free
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign free  = CW'(DEPTH) - count;
    assign dout  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rfe_regs.sv
module rfe_regs
    import rfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        apply,
    input  cmd_t        cmd,
    input  logic        walk_last,
    output xy_t         dst,
    output xy_t         size,
    output logic [31:0] pattern,
    output logic [31:0] fg,
    output logic [31:0] bg,
    output ctrl_t       ctrl,
    output logic        launch
);
    localparam logic [REG_AW-1:0] OFF_TRIG = OFF_SIZE | OP_FILL;

    always_comb begin
        launch = apply && (cmd.addr == OFF_TRIG)
                 && (cmd.data[31:16] != '0) && (cmd.data[15:0] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst     <= '0;
            size    <= '0;
            pattern <= '0;
            fg      <= '0;
            bg      <= '0;
            ctrl    <= '0;
        end else begin
            if (apply) begin
                case (cmd.addr)
                    OFF_DST:            dst     <= cmd.data;
                    OFF_SIZE, OFF_TRIG: size    <= cmd.data;
                    OFF_PAT:            pattern <= cmd.data;
                    OFF_FG:             fg      <= cmd.data;
                    OFF_BG:             bg      <= cmd.data;
                    OFF_CTRL:           ctrl    <= cmd.data[1:0];
                    default:            ;
                endcase
            end
            if (walk_last) dst.y <= dst.y + size.y;
        end
    end
endmodule

// File: rtl/rfe_span_walker.sv
module rfe_span_walker
    import rfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] width,
    input  logic [15:0] height,
    input  logic        clip,
    output logic        busy,
    output logic        last,
    output logic [16:0] col,
    output logic [15:0] row
);
    logic [16:0] span_q;
    logic [15:0] h_q;
    logic        row_end;

    assign row_end = (col == span_q - 17'd1);
    assign last    = busy && row_end && (row == h_q - 16'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            span_q <= '0;
            h_q    <= '0;
            col    <= '0;
            row    <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            span_q <= span_len(width, clip);
            h_q    <= height;
            col    <= '0;
            row    <= '0;
        end else if (busy) begin
            if (row_end) begin
                col <= '0;
                if (last) busy <= 1'b0;
                else      row  <= row + 16'd1;
            end else begin
                col <= col + 17'd1;
            end
        end
    end
endmodule

// File: rtl/rfe_expander.sv
module rfe_expander
    import rfe_pkg::*;
(
    input  logic                     active,
    input  logic [$clog2(GROUP)-1:0] lane,
    input  logic [GROUP-1:0]         pattern,
    input  logic [31:0]              fg,
    input  logic [31:0]              bg,
    input  logic                     transp,
    output logic                     we,
    output logic [31:0]              data
);
    logic [GROUP-1:0] lane_bits;

    // lane 0 (leftmost pixel) takes the most significant pattern bit
    for (genvar g = 0; g < GROUP; g++) begin : g_lane
        assign lane_bits[g] = pattern[GROUP-1-g];
    end

    logic hit;
    assign hit  = lane_bits[lane];
    assign we   = active && (hit || !transp);
    assign data = hit ? fg : bg;
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rfe_pkg::*;
#(
    parameter int FIFO_DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic [REG_AW-1:0]   rd_addr,
    output logic [31:0]         rd_data,
    output logic                mem_we,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [31:0]         mem_wdata
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int CMD_W = $bits(cmd_t);

    cmd_t             push_cmd, head;
    logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [CNT_W-1:0] free_cnt;

    xy_t         dst, size;
    logic [31:0] pattern, fg, bg;
    ctrl_t       ctrl;
    logic        launch;

    logic        walk_busy, walk_last;
    logic [16:0] col;
    logic [15:0] row;
    logic        busy_any;

    assign push_cmd  = '{addr: reg_addr, data: reg_wdata};
    assign fifo_push = reg_wr_en && !fifo_full;
    assign fifo_pop  = !fifo_empty && !walk_busy;
    assign busy_any  = walk_busy || !fifo_empty;

    rfe_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(CMD_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .din   (push_cmd),
        .pop   (fifo_pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .free  (free_cnt)
    );

    rfe_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .apply     (fifo_pop),
        .cmd       (head),
        .walk_last (walk_last),
        .dst       (dst),
        .size      (size),
        .pattern   (pattern),
        .fg        (fg),
        .bg        (bg),
        .ctrl      (ctrl),
        .launch    (launch)
    );

    rfe_span_walker u_walk (
        .clk    (clk),
        .rst    (rst),
        .start  (launch),
        .width  (head.data[31:16]),
        .height (head.data[15:0]),
        .clip   (ctrl.clip),
        .busy   (walk_busy),
        .last   (walk_last),
        .col    (col),
        .row    (row)
    );

    rfe_expander u_exp (
        .active  (walk_busy),
        .lane    (col[$clog2(GROUP)-1:0]),
        .pattern (pattern),
        .fg      (fg),
        .bg      (bg),
        .transp  (ctrl.transp),
        .we      (mem_we),
        .data    (mem_wdata)
    );

    assign mem_addr = pixel_addr(dst, row, col[15:0]);

    always_comb begin
        case (rd_addr)
            OFF_STAT: rd_data = {24'd0, {8{busy_any}}};
            OFF_FREE: rd_data = 32'(free_cnt);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker
    import rfe_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic              mem_we,
    input logic [31:0]       mem_wdata,
    input logic [31:0]       fg,
    input logic              transp,
    input logic              clip,
    input logic [16:0]       col,
    input logic [15:0]       size_w,
    input logic [15:0]       size_h,
    input logic [15:0]       dst_y,
    input logic              walk_busy,
    input logic              walk_last,
    input logic              fifo_pop,
    input logic [REG_AW-1:0] head_addr,
    input logic [31:0]       head_data,
    input logic [CNT_W-1:0]  free_cnt
);
    logic zero_trig;
    assign zero_trig = fifo_pop && (head_addr == (OFF_SIZE | OP_FILL))
                       && ((head_data[31:16] == '0) || (head_data[15:0] == '0));

    AST_WE_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> walk_busy); // R3
    AST_TRANSP_FG: assert property (@(posedge clk) disable iff (rst)
        (mem_we && transp) |-> (mem_wdata == fg)); // R4
    AST_CLIP_EDGE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && clip) |-> (col < {1'b0, size_w})); // R5
    AST_Y_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        walk_last |=> (dst_y == $past(dst_y) + $past(size_h))); // R6
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && (free_cnt == '0) && !fifo_pop) |=> (free_cnt == '0)); // R9
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        zero_trig |=> !walk_busy); // R10
endmodule

bind rect_fill_engine rfe_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .fg        (fg),
    .transp    (ctrl.transp),
    .clip      (ctrl.clip),
    .col       (col),
    .size_w    (size.x),
    .size_h    (size.y),
    .dst_y     (dst.y),
    .walk_busy (walk_busy),
    .walk_last (walk_last),
    .fifo_pop  (fifo_pop),
    .head_addr (head.addr),
    .head_data (head.data),
    .free_cnt  (free_cnt)
);

// File: tb/rect_fill_engine_test.sv
module rect_fill_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        mem_we;
    logic [27:0] mem_addr;
    logic [31:0] mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int n_seen = 0;

    logic [59:0] exq[$];
    logic [15:0] m_x = 0, m_y = 0;
    logic [31:0] m_pat = 0, m_fg = 0, m_bg = 0;
    logic        m_transp = 0, m_clip = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rect_fill_engine uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected pixel stream for one trigger
    task automatic model_trigger(input logic [31:0] d);
        logic [15:0] w, h;
        int span;
        w = d[31:16];
        h = d[15:0];
        if (w != 0 && h != 0) begin
            span = m_clip ? int'(w) : ((int'(w) + 31) / 32) * 32;
            for (int r = 0; r < int'(h); r++) begin
                for (int c = 0; c < span; c++) begin
                    logic bitv;
                    logic [15:0] py, px;
                    logic [27:0] a;
                    bitv = m_pat[31 - (c % 32)];
                    py = m_y + 16'(r);
                    px = m_x + 16'(c);
                    a = (28'(py) << 11) + 28'(px);
                    if (bitv || !m_transp) exq.push_back({a, bitv ? m_fg : m_bg});
                end
            end
            m_y = m_y + h;
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit upd = 1'b1);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        if (upd) begin
            case (a)
                12'h000: begin m_x = d[31:16]; m_y = d[15:0]; end
                12'h008: m_pat = d;
                12'h00C: m_fg = d;
                12'h010: m_bg = d;
                12'h014: begin m_transp = d[0]; m_clip = d[1]; end
                12'h204: model_trigger(d);
                default: ;
            endcase
        end
        @(posedge clk);
        #1 reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        rd_addr = 12'h100;
        @(negedge clk);
        while (rd_data != 0 && n < 6000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " R8 status idle"}, 64'(rd_data), 64'd0);
        chk({req, " R3 all expected pixels seen"}, 64'(exq.size()), 64'd0);
        exq.delete();
    endtask

    // pixel write monitor against the expected stream (R3 R4 R5 R7)
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            n_seen++;
            if (exq.size() == 0) begin
                chk("R2/R10 unexpected pixel write", {4'd0, mem_addr, mem_wdata}, 64'hFFFF_FFFF_FFFF_FFFF);
            end else begin
                logic [59:0] e;
                e = exq.pop_front();
                chk("R3/R4/R5/R7 pixel write", {4'd0, mem_addr, mem_wdata}, {4'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seen0;
        void'($urandom(32'h0000_5EED));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        rd_addr = 12'h100;
        @(negedge clk);
        chk("R11 status after reset", 64'(rd_data), 64'd0);
        chk("R11 no write after reset", 64'(mem_we), 64'd0);
        rd_addr = 12'h104;
        @(negedge clk);
        chk("R11 free slots after reset", 64'(rd_data), 64'd32);

        // R1 R2 R3 R7 R5: solid clipped fill
        wr(12'h000, {16'd5, 16'd3});
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h00C, 32'h1111_2222);
        wr(12'h010, 32'h3333_4444);
        wr(12'h014, 32'h2);
        wr(12'h204, {16'd10, 16'd2});
        rd_addr = 12'h100;
        @(negedge clk);
        chk("R8 busy during fill", 64'(rd_data != 0), 64'd1);
        wait_idle("R2 clipped solid");

        // R5 padding without clip, R6 Y advanced from previous fill
        wr(12'h014, 32'h0);
        wr(12'h008, 32'hF0F0_00FF);
        wr(12'h204, {16'd10, 16'd2});
        wait_idle("R5 padded / R6 advance");

        // R2 plain size write does not start
        seen0 = n_seen;
        wr(12'h004, {16'd8, 16'd8});
        repeat (20) @(negedge clk);
        chk("R2 plain size write no pixels", 64'(n_seen), 64'(seen0));

        // R4 transparent stipple crossing a group boundary
        wr(12'h000, {16'd100, 16'd40});
        wr(12'h008, 32'hA5A5_F00F);
        wr(12'h014, 32'h3);
        wr(12'h204, {16'd40, 16'd3});
        wait_idle("R4 transparent");

        // R10 zero sizes then a 1x1 fill checks Y unchanged
        seen0 = n_seen;
        wr(12'h204, {16'd0, 16'd5});
        wr(12'h204, {16'd3, 16'd0});
        repeat (10) @(negedge clk);
        chk("R10 zero size no pixels", 64'(n_seen), 64'(seen0));
        wr(12'h014, 32'h0);
        wr(12'h204, {16'd1, 16'd1});
        wait_idle("R10 origin kept");

        // R9 queue fill while busy, overflow discarded
        wr(12'h000, {16'd0, 16'd200});
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h00C, 32'hCAFE_0001);
        wr(12'h014, 32'h2);
        wr(12'h204, {16'd64, 16'd20});
        for (int i = 0; i < 32; i++) wr(12'h008, (i == 31) ? 32'hF0F0_F0F0 : $urandom);
        rd_addr = 12'h104;
        @(negedge clk);
        chk("R9 free slots zero when full", 64'(rd_data), 64'd0);
        wr(12'h00C, 32'hDEAD_BEEF, 1'b0);
        wr(12'h00C, 32'hDEAD_BEE0, 1'b0);
        rd_addr = 12'h104;
        @(negedge clk);
        chk("R9 still full after drop", 64'(rd_data), 64'd0);
        rd_addr = 12'h100;
        @(negedge clk);
        chk("R8 busy with queued commands", 64'(rd_data != 0), 64'd1);
        wait_idle("R9 queued fill");
        rd_addr = 12'h104;
        @(negedge clk);
        chk("R9 free slots restored", 64'(rd_data), 64'd32);
        wr(12'h204, {16'd5, 16'd1});
        wait_idle("R9 dropped colour kept");

        // randomised fills, queued back to back
        for (int i = 0; i < 48; i++) begin
            logic [31:0] pat;
            pat = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
            wr(12'h000, {16'($urandom % 200), 16'($urandom % 300)});
            wr(12'h008, pat);
            wr(12'h00C, $urandom);
            wr(12'h010, $urandom);
            wr(12'h014, 32'($urandom % 4));
            wr(12'h204, {16'($urandom % 80), 16'($urandom % 4)});
            if (i % 4 == 3) wait_idle("R3 random");
        end
        wait_idle("R3 random end");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule